// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes over a single half-duplex I/O line in the asynchronous character format that smart cards use. Software configures the block through a small register write port and then writes bytes one at a time into a holding register. The sequencer moves each byte into its shift register and sends a low start bit, eight data bits and a parity bit. It then releases the line for two guard bit times. All bit timing comes from an external enable that pulses for one clock cycle per bit time.

While the first guard bit is on the line, the receiving card may pull the line low to reject the character. The block samples the line at the end of that bit. If it sees the rejection, it sends the same character again straight after the guard time. Once the retransmission budget is spent, the block raises an error flag, drops the character and holds off further traffic until software clears the flag. Three status outputs report a free holding register, an idle transmitter with nothing pending, and the error condition.

Top module: `sc_char_tx`

## Requirements
- R1: After reset `line_out` is high, `tx_empty` is 1, `tx_end` is 1 and `err_flag` is 0.
- R2: Each character lasts exactly one `bit_tick` period per bit, in this order: a low start bit, eight data bits, a parity bit, then two guard bits with the line released (high).
- R3: Config bit 2 (`wr_addr` 1) chooses the bit order: 0 sends bit 0 of the byte first, 1 sends bit 7 first.
- R4: Config bit 1 chooses the parity sense: 0 makes the count of ones in data plus parity even, 1 makes it odd.
- R5: Config bit 3 inverts the line level of the data and parity bits. The start bit and the guard bits are not affected.
- R6: A write to `wr_addr` 0 loads the holding register and clears `tx_empty` and `tx_end` in the next cycle. `tx_empty` returns to 1 when the byte moves into the shifter. `tx_end` returns to 1 once the line is idle with no byte pending and no error.
- R7: If `line_in` is low at the `bit_tick` that ends the first guard bit, the same character is sent again, starting directly after the second guard bit.
- R8: After MAX_RETRY (default 3) retransmissions of one character that are all rejected, `err_flag` is set, the character is dropped and no further character starts.
- R9: While `err_flag` is 1, `tx_end` stays 0 and data writes are ignored (`tx_empty` does not change). Writing 1 to bit 0 at `wr_addr` 2 clears the flag.
- R10: Config bit 0 enables the transmitter. Clearing it aborts the current character, and the line is released by the second clock edge after the write. No character starts while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data, 1 config, 2 flag clear |
| wr_data | input | 8 | Write data |
| line_in | input | 1 | Sampled level of the I/O line |
| line_out | output | 1 | Driven line level (1 = released) |
| tx_empty | output | 1 | Holding register free |
| tx_end | output | 1 | Transmitter idle, nothing pending, no error |
| err_flag | output | 1 | Retry limit exceeded |

## Verification
A sequencer that slips its bit count produces a frame whose bits or parity land in the wrong slot. This shows up at `line_out` within the same character, at most twelve bit times later. A wrong retry count shows up as an extra or missing retransmission, or as an `err_flag` that is early or missing, one guard time after the last rejection. Faults in the holding register or in the flags show up at `tx_empty` and `tx_end` one cycle after a write or after the byte is taken.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    // configuration register, bit 0 = enable
    typedef struct packed {
        logic inv;
        logic msb;
        logic odd;
        logic en;
    } tx_cfg_t;

    // what is currently on the line
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_GUARD
    } tx_phase_t;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_CLR  = 2'd2;

    localparam int CFG_W = $bits(tx_cfg_t);

endpackage

// File: rtl/sc_tx_regs.sv
module sc_tx_regs
    import sc_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              err_set,
    output logic [DATA_W-1:0] hold,
    output logic              empty,
    output tx_cfg_t           cfg,
    output logic              err_flag
);

    logic wr_data_ok;
    assign wr_data_ok = wr_en && (wr_addr == A_DATA) && !err_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            empty    <= 1'b1;
            cfg      <= '0;
            err_flag <= 1'b0;
        end else begin
            if (wr_data_ok) begin
                hold  <= wr_data;
                empty <= 1'b0;
            end else if (take) begin
                empty <= 1'b1;
            end
            if (wr_en && wr_addr == A_CFG)
                cfg <= tx_cfg_t'(wr_data[CFG_W-1:0]);
            if (err_set)
                err_flag <= 1'b1;
            else if (wr_en && wr_addr == A_CLR && wr_data[0])
                err_flag <= 1'b0;
        end
    end

    // R9: a data write during an error leaves the holding register alone
    p_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DATA && err_flag && !take)
            |=> ($stable(hold) && empty == $past(empty)));

endmodule

// File: rtl/sc_tx_seq.sv
module sc_tx_seq
    import sc_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MAX_RETRY  = 3,
    parameter int GUARD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  tx_cfg_t           cfg,
    input  logic [DATA_W-1:0] hold,
    input  logic              pending,
    input  logic              err_flag,
    input  logic              line_in,
    output logic              take,
    output logic              err_set,
    output logic              busy,
    output logic              line_out
);

    localparam int CNT_W = $clog2((DATA_W > GUARD_BITS ? DATA_W : GUARD_BITS) + 1);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);

    function automatic logic [DATA_W-1:0] order(input logic [DATA_W-1:0] d, input logic msb);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++)
            r[i] = msb ? d[DATA_W-1-i] : d[i];
        return r;
    endfunction

    tx_phase_t         phase;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] keep;
    logic              par_bit;
    logic [RTY_W-1:0]  retries;
    logic              rejected;
    logic              line_q;

    logic guard_last, can_retry, frame_end, go_retry, go_load;

    assign guard_last = (phase == PH_GUARD) && (cnt == CNT_W'(GUARD_BITS - 1));
    assign can_retry  = retries < RTY_W'(MAX_RETRY);
    assign frame_end  = bit_tick && cfg.en && guard_last;
    assign go_retry   = frame_end && rejected && can_retry;
    assign err_set    = frame_end && rejected && !can_retry;
    assign go_load    = bit_tick && cfg.en && pending && !err_flag &&
                        (phase == PH_IDLE || (guard_last && !rejected));
    assign take       = go_load;
    assign busy       = (phase != PH_IDLE);
    assign line_out   = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            keep     <= '0;
            par_bit  <= 1'b0;
            retries  <= '0;
            rejected <= 1'b0;
            line_q   <= 1'b1;
        end else if (!cfg.en) begin
            phase  <= PH_IDLE;
            line_q <= 1'b1;
        end else if (bit_tick) begin
            if (go_load) begin
                shreg    <= order(hold, cfg.msb);
                keep     <= order(hold, cfg.msb);
                par_bit  <= (^hold) ^ cfg.odd;
                retries  <= '0;
                rejected <= 1'b0;
                phase    <= PH_START;
                line_q   <= 1'b0;
            end else if (go_retry) begin
                shreg    <= keep;
                retries  <= retries + 1'b1;
                rejected <= 1'b0;
                phase    <= PH_START;
                line_q   <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: line_q <= 1'b1;
                    PH_START: begin
                        line_q <= shreg[0] ^ cfg.inv;
                        shreg  <= shreg >> 1;
                        cnt    <= CNT_W'(1);
                        phase  <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (cnt == CNT_W'(DATA_W)) begin
                            line_q <= par_bit ^ cfg.inv;
                            phase  <= PH_PARITY;
                        end else begin
                            line_q <= shreg[0] ^ cfg.inv;
                            shreg  <= shreg >> 1;
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    PH_PARITY: begin
                        line_q <= 1'b1;
                        cnt    <= '0;
                        phase  <= PH_GUARD;
                    end
                    PH_GUARD: begin
                        line_q <= 1'b1;
                        if (cnt == '0)
                            rejected <= !line_in;
                        if (guard_last)
                            phase <= PH_IDLE;
                        else
                            cnt <= cnt + 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R2: start bit is driven low, guard bits leave the line released
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START) |-> !line_q);
    p_guard_released_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GUARD) |-> line_q);
    // R8: retransmission count never exceeds the budget
    p_retry_bound_r8: assert property (@(posedge clk) disable iff (rst)
        retries <= RTY_W'(MAX_RETRY));
    // R10: disabled transmitter releases the line and goes idle
    p_disable_release_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (line_q && phase == PH_IDLE));

    initial begin
        a_guard_cfg: assert (GUARD_BITS >= 2);
    end

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MAX_RETRY  = 3,
    parameter int GUARD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_in,
    output logic              line_out,
    output logic              tx_empty,
    output logic              tx_end,
    output logic              err_flag
);

    logic [DATA_W-1:0] hold;
    tx_cfg_t           cfg;
    logic              take, err_set, busy;

    sc_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .take     (take),
        .err_set  (err_set),
        .hold     (hold),
        .empty    (tx_empty),
        .cfg      (cfg),
        .err_flag (err_flag)
    );

    sc_tx_seq #(
        .DATA_W     (DATA_W),
        .MAX_RETRY  (MAX_RETRY),
        .GUARD_BITS (GUARD_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .cfg      (cfg),
        .hold     (hold),
        .pending  (!tx_empty),
        .err_flag (err_flag),
        .line_in  (line_in),
        .take     (take),
        .err_set  (err_set),
        .busy     (busy),
        .line_out (line_out)
    );

    assign tx_end = !busy && tx_empty && !err_flag;

    // R9: error flag keeps transmit-end low
    p_err_blocks_end_r9: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !tx_end);
    // R6: an accepted data write drops transmit-end
    p_wr_clears_end_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_DATA && !err_flag) |=> !tx_end);

endmodule

// File: tb/sc_char_tx_bench.sv
module sc_char_tx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       line_in = 1'b1;
    logic       line_out, tx_empty, tx_end, err_flag;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [1:0] tdiv = 2'd0;

    sc_char_tx u_sc_char_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .line_in(line_in),
        .line_out(line_out), .tx_empty(tx_empty), .tx_end(tx_end),
        .err_flag(err_flag)
    );

    always #5 clk = ~clk;

    // bit tick every 4 cycles
    always @(posedge clk) begin
        tdiv     <= tdiv + 2'd1;
        bit_tick <= (tdiv == 2'd2);
        cyc      <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cfg: [3] invert, [2] msb first, [1] odd parity, [0] enable
    function automatic logic [9:0] exp_frame(input logic [7:0] d, input logic [3:0] c);
        logic [9:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            f[i+1] = (c[2] ? d[7-i] : d[i]) ^ c[3];
        f[9] = (c[1] ? ~^d : ^d) ^ c[3];
        return f;
    endfunction

    task automatic capture(input logic pull, output logic found,
                           output logic [9:0] got, output logic guard_hi);
        found = 1'b0; got = '0; guard_hi = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (line_out == 1'b0) begin found = 1'b1; break; end
        end
        if (!found) return;
        got[0] = line_out;
        for (int b = 1; b < 10; b++) begin
            repeat (4) @(negedge clk);
            got[b] = line_out;
        end
        repeat (4) @(negedge clk);
        guard_hi = line_out;
        if (pull) line_in = 1'b0;
        repeat (4) @(negedge clk);
        line_in = 1'b1;
        guard_hi = guard_hi & line_out;
    endtask

    task automatic send_check(input logic [7:0] d, input logic [3:0] c, input int npull, input string tag);
        logic found, gh;
        logic [9:0] got;
        wr(2'd1, {4'd0, c});
        wr(2'd0, d);
        chk({tag, " R6 empty after write"}, tx_empty, 1'b0);
        chk({tag, " R6 end after write"}, tx_end, 1'b0);
        for (int k = 0; k <= npull; k++) begin
            capture(k < npull, found, got, gh);
            chk({tag, " R2 start seen"}, found, 1'b1);
            chk({tag, (k > 0) ? " R7 resent frame" : " R2 R3 R4 R5 frame"}, got, exp_frame(d, c));
            chk({tag, " R2 guard released"}, gh, 1'b1);
        end
        repeat (8) @(negedge clk);
        chk({tag, " R6 end after frame"}, tx_end, 1'b1);
        chk({tag, " R6 empty after frame"}, tx_empty, 1'b1);
    endtask

    initial begin
        logic found, gh;
        logic [9:0] got;
        logic stayed;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 line", line_out, 1'b1);
        chk("R1 empty", tx_empty, 1'b1);
        chk("R1 end", tx_end, 1'b1);
        chk("R1 err", err_flag, 1'b0);

        // directed order and parity corners
        send_check(8'h01, 4'b0001, 0, "R3 lsb first, R4 even");
        send_check(8'h01, 4'b0101, 0, "R3 msb first");
        send_check(8'h03, 4'b0011, 0, "R4 odd parity");
        send_check(8'h00, 4'b1001, 0, "R5 inverted");
        send_check(8'hA5, 4'b0001, 2, "R7 two rejections");

        // random mix
        for (int n = 0; n < 20; n++) begin
            logic [7:0] d;
            logic [3:0] c;
            d = 8'($urandom);
            c = {3'($urandom), 1'b1};
            send_check(d, c, int'($urandom % 3), "random");
        end

        // back to back: second byte written while first is on the line
        wr(2'd1, 4'b0001);
        wr(2'd0, 8'h5C);
        wait (tx_empty == 1'b1);
        @(negedge clk);
        chk("R6 empty after take", tx_empty, 1'b1);
        chk("R6 end busy", tx_end, 1'b0);
        wr(2'd0, 8'hC3);
        capture(1'b0, found, got, gh);
        chk("R2 b2b first", got, exp_frame(8'h5C, 4'b0001));
        capture(1'b0, found, got, gh);
        chk("R2 b2b second", got, exp_frame(8'hC3, 4'b0001));
        repeat (8) @(negedge clk);

        // R8 retry limit: original plus three retransmissions all rejected
        wr(2'd0, 8'h96);
        for (int k = 0; k < 4; k++) begin
            capture(1'b1, found, got, gh);
            chk("R8 attempt frame", got, exp_frame(8'h96, 4'b0001));
        end
        repeat (8) @(negedge clk);
        chk("R8 err set", err_flag, 1'b1);
        chk("R9 end low on err", tx_end, 1'b0);
        stayed = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (line_out == 1'b0) stayed = 1'b0;
        end
        chk("R8 dropped, no fifth start", stayed, 1'b1);
        wr(2'd0, 8'h11);
        chk("R9 write ignored", tx_empty, 1'b1);
        wr(2'd2, 8'h01);
        chk("R9 err cleared", err_flag, 1'b0);
        chk("R9 end back", tx_end, 1'b1);

        // R10 abort by clearing enable
        wr(2'd0, 8'h00);
        capture(1'b0, found, got, gh);
        wr(2'd1, 4'b0000);
        @(negedge clk);
        chk("R10 line released", line_out, 1'b1);
        wr(2'd0, 8'h00);
        stayed = 1'b1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (line_out == 1'b0) stayed = 1'b0;
        end
        chk("R10 no start while off", stayed, 1'b1);
        chk("R10 byte still pending", tx_empty, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule